// File: doc/BRIEF.md
# Soft-Start, Fault and Restart Sequencer

This block sequences the start-up of a primary-side switching controller. A single unsigned ramp code stands in for the soft-start capacitor. After the supply and input-voltage comparators allow a start, the ramp charges and sets the duty cycle of the external duty comparator. Past the end-of-soft-start code it keeps charging toward a second code, where the bias linear regulator is switched off for thermal protection.

Any of four fault flags stops the gate in the same cycle. A fault also drives the ramp to full scale while a fault indicator pulses. The ramp then discharges in two steps: a fast one down to the end-of-soft-start code, and a slow one down to a low retry code. After that the block goes back to waiting for start conditions.

Two other events switch the regulator off. One is the appearance of the encoded drive signal from the secondary side. The other is the absence of that signal at the end of soft-start when secondary control is selected. Once off, the regulator stays off until the next retry. A volt-second limit hit cuts the gate only for the current switching cycle and is not treated as a fault.

Top module: `ssfr_seq`

## Requirements
- R1: After reset, ramp is 0, gate_en is 0, flt_ind is 0 and lr_en is 1. The block leaves its wait state only when three conditions hold: the start flag for the selected mode is set (vcc_ok_lr when mode_trickle=0, vcc_ok_tc when mode_trickle=1), vcc_uv is 0 and vin_uv is 0. gate_en goes high one clock after the conditions are sampled.
- R2: While the gate is allowed, the ramp rises by CHG_STEP (default 4) each clock from its starting code. It saturates at LR_OFF_CODE (default 998) and never exceeds it.
- R3: lr_en goes low one clock after the ramp first shows LR_OFF_CODE.
- R4: lr_en is low in the same cycle that enc_present is high. lr_en stays low after enc_present falls, until a retry.
- R5: When sec_mode=1 and enc_present has not been seen, lr_en goes low one clock after the ramp shows SS_END_CODE (default 716). When sec_mode=0, lr_en stays high past that code.
- R6: Four fault flags apply while the gate is allowed: oc_trip, vin_uv, vcc_uv and enc_lost. Any of them forces gate_en low in the same cycle. On the next clock, flt_ind is 1 and the ramp is all ones (1023).
- R7: flt_ind stays high for exactly FLT_LEN clocks (default 16), during which the ramp holds all ones.
- R8: After the pulse, the ramp falls by FAST_STEP (default 32) per clock, clamped at SS_END_CODE. It holds that code one extra clock, then falls by SLOW_STEP (default 2) per clock, clamped at RETRY_CODE (default 51). One clock after RETRY_CODE shows, lr_en is 1 again. If start conditions hold, gate_en returns one clock later and charging resumes from RETRY_CODE.
- R9: Fault flags raised during the indicator pulse or either discharge phase neither restart nor alter the sequence.
- R10: vsl_hit forces gate_en low in the same cycle. gate_en stays low until the clock that samples cycle_start high. flt_ind stays 0 and the ramp keeps charging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vcc_ok_lr | input | 1 | Supply above the start level used with the linear regulator |
| vcc_ok_tc | input | 1 | Supply above the start level used with the trickle charger |
| vcc_uv | input | 1 | Supply below the shared falling threshold |
| vin_uv | input | 1 | Input voltage below its undervoltage threshold |
| oc_trip | input | 1 | Overcurrent comparator tripped |
| enc_lost | input | 1 | Encoded drive signal lost |
| enc_present | input | 1 | Encoded drive signal detected |
| mode_trickle | input | 1 | 1 selects the trickle-charger start level |
| sec_mode | input | 1 | 1 when secondary-side control is expected |
| vsl_hit | input | 1 | Volt-second limit reached in this switching cycle |
| cycle_start | input | 1 | Start of a new switching cycle |
| gate_en | output | 1 | Gate drive allowed |
| flt_ind | output | 1 | Fault indicator pulse |
| lr_en | output | 1 | Linear regulator enable |
| ramp | output | 10 | Ramp code for the duty comparator |

## Verification
Some outputs react to inputs in the same cycle: gate_en to a fault flag or vsl_hit, and lr_en to enc_present. The bench checks these one time step after driving the input, before any clock edge. Other results are registered and appear after one clock: the state change, the ramp step, the pulse start and the regulator lock. The bench drives inputs on the falling edge and reads these on the following falling edge. Timeouts and ramp phases take a fixed number of clocks. For these, the bench counts clocks until the ramp shows a code and compares the count, and each ramp step, with values worked out from the step sizes and codes.

// File: rtl/ssfr_pkg.sv
package ssfr_pkg;

   typedef enum logic [2:0] {
      RC_HOLD,
      RC_CHARGE,
      RC_FULL,
      RC_FAST,
      RC_SLOW
   } ramp_cmd_e;

   typedef enum logic [2:0] {
      ST_WAIT,
      ST_SOFT,
      ST_RUN,
      ST_FLAG,
      ST_FAST,
      ST_SLOW
   } seq_state_e;

endpackage

// File: rtl/ssfr_ramp.sv
module ssfr_ramp
   import ssfr_pkg::*;
#(
   parameter int RAMP_W      = 10,
   parameter int CHG_STEP    = 4,
   parameter int FAST_STEP   = 32,
   parameter int SLOW_STEP   = 2,
   parameter int TOP_CODE    = 998,
   parameter int MID_CODE    = 716,
   parameter int LOW_CODE    = 51
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ramp_cmd_e         cmd,
   output logic [RAMP_W-1:0] ramp_q
);

   localparam int XW = RAMP_W + 1;
   localparam logic [XW-1:0] TOP_X  = XW'(TOP_CODE);
   localparam logic [XW-1:0] MID_X  = XW'(MID_CODE);
   localparam logic [XW-1:0] LOW_X  = XW'(LOW_CODE);
   localparam logic [XW-1:0] CHG_X  = XW'(CHG_STEP);
   localparam logic [XW-1:0] FAST_X = XW'(FAST_STEP);
   localparam logic [XW-1:0] SLOW_X = XW'(SLOW_STEP);

   logic [XW-1:0] cur_x;
   logic [XW-1:0] nxt_x;

   assign cur_x = {1'b0, ramp_q};

   always_comb begin
      nxt_x = cur_x;
      case (cmd)
         RC_CHARGE: nxt_x = (cur_x + CHG_X >= TOP_X) ? TOP_X : cur_x + CHG_X;
         RC_FULL:   nxt_x = {1'b0, {RAMP_W{1'b1}}};
         RC_FAST:   nxt_x = (cur_x >= MID_X + FAST_X) ? cur_x - FAST_X : MID_X;
         RC_SLOW:   nxt_x = (cur_x >= LOW_X + SLOW_X) ? cur_x - SLOW_X : LOW_X;
         default:   nxt_x = cur_x;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ramp_q <= '0;
      else        ramp_q <= nxt_x[RAMP_W-1:0];
   end

endmodule

// File: rtl/ssfr_ctrl.sv
module ssfr_ctrl
   import ssfr_pkg::*;
#(
   parameter int RAMP_W      = 10,
   parameter int SS_END_CODE = 716,
   parameter int LR_OFF_CODE = 998,
   parameter int RETRY_CODE  = 51,
   parameter int FLT_LEN     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_ok,
   input  logic              fault_any,
   input  logic              enc_present,
   input  logic              sec_mode,
   input  logic [RAMP_W-1:0] ramp_q,
   output ramp_cmd_e         cmd,
   output logic              active,
   output logic              flt_ind,
   output logic              lr_en
);

   localparam int CW = (FLT_LEN > 1) ? $clog2(FLT_LEN) : 1;
   localparam logic [CW-1:0]     CNT_LAST = CW'(FLT_LEN - 1);
   localparam logic [RAMP_W-1:0] MID_V    = RAMP_W'(SS_END_CODE);
   localparam logic [RAMP_W-1:0] TOP_V    = RAMP_W'(LR_OFF_CODE);
   localparam logic [RAMP_W-1:0] LOW_V    = RAMP_W'(RETRY_CODE);

   seq_state_e    st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          lr_off_q, lr_off_d;
   logic          retry_now;

   assign active    = (st_q == ST_SOFT) || (st_q == ST_RUN);
   assign flt_ind   = (st_q == ST_FLAG);
   assign retry_now = (st_q == ST_SLOW) && (ramp_q == LOW_V);
   assign lr_en     = !lr_off_q && !enc_present;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      cmd   = RC_HOLD;
      case (st_q)
         ST_WAIT: if (start_ok) st_d = ST_SOFT;
         ST_SOFT, ST_RUN: begin
            if (fault_any) begin
               st_d  = ST_FLAG;
               cnt_d = '0;
               cmd   = RC_FULL;
            end else begin
               cmd = RC_CHARGE;
               if (st_q == ST_SOFT && ramp_q >= MID_V) st_d = ST_RUN;
            end
         end
         ST_FLAG: begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) st_d = ST_FAST;
         end
         ST_FAST: begin
            cmd = RC_FAST;
            if (ramp_q == MID_V) st_d = ST_SLOW;
         end
         ST_SLOW: begin
            cmd = RC_SLOW;
            if (ramp_q == LOW_V) st_d = ST_WAIT;
         end
         default: st_d = ST_WAIT;
      endcase
   end

   // regulator lock: any cause sets it, only a retry clears it
   always_comb begin
      lr_off_d = lr_off_q;
      if (retry_now)
         lr_off_d = 1'b0;
      else if (enc_present
               || (active && ramp_q >= TOP_V)
               || (active && sec_mode && ramp_q >= MID_V))
         lr_off_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_WAIT;
         cnt_q    <= '0;
         lr_off_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         cnt_q    <= cnt_d;
         lr_off_q <= lr_off_d;
      end
   end

endmodule

// File: rtl/ssfr_gate.sv
module ssfr_gate #(
   parameter bit VSL_LATCH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic fault_any,
   input  logic vsl_hit,
   input  logic cycle_start,
   output logic gate_en
);

   logic cut;

   generate
      if (VSL_LATCH) begin : g_latch
         logic cut_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cut_q <= 1'b0;
            else if (cycle_start) cut_q <= 1'b0;
            else if (vsl_hit)     cut_q <= 1'b1;
         end
         assign cut = cut_q;
      end else begin : g_level
         assign cut = 1'b0;
      end
   endgenerate

   assign gate_en = active && !fault_any && !vsl_hit && !cut;

endmodule

// File: rtl/ssfr_seq.sv
module ssfr_seq
   import ssfr_pkg::*;
#(
   parameter int RAMP_W      = 10,
   parameter int CHG_STEP    = 4,
   parameter int FAST_STEP   = 32,
   parameter int SLOW_STEP   = 2,
   parameter int SS_END_CODE = 716,
   parameter int LR_OFF_CODE = 998,
   parameter int RETRY_CODE  = 51,
   parameter int FLT_LEN     = 16,
   parameter bit VSL_LATCH   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vcc_ok_lr,
   input  logic              vcc_ok_tc,
   input  logic              vcc_uv,
   input  logic              vin_uv,
   input  logic              oc_trip,
   input  logic              enc_lost,
   input  logic              enc_present,
   input  logic              mode_trickle,
   input  logic              sec_mode,
   input  logic              vsl_hit,
   input  logic              cycle_start,
   output logic              gate_en,
   output logic              flt_ind,
   output logic              lr_en,
   output logic [RAMP_W-1:0] ramp
);

   localparam int RAMP_MAX = (1 << RAMP_W) - 1;

   generate
      if (RAMP_W < 4 || RAMP_W > 16) begin : g_bad_width
         $error("ssfr_seq: RAMP_W out of range");
      end
      if (!(RETRY_CODE < SS_END_CODE && SS_END_CODE < LR_OFF_CODE
            && LR_OFF_CODE < RAMP_MAX)) begin : g_bad_codes
         $error("ssfr_seq: codes must rise retry < end < timeout < full scale");
      end
      if (CHG_STEP < 1 || FAST_STEP < 1 || SLOW_STEP < 1
          || SS_END_CODE + FAST_STEP > RAMP_MAX) begin : g_bad_steps
         $error("ssfr_seq: step sizes out of range");
      end
      if (FLT_LEN < 2) begin : g_bad_pulse
         $error("ssfr_seq: FLT_LEN must be at least 2");
      end
   endgenerate

   ramp_cmd_e cmd;
   logic      active;
   logic      start_ok;
   logic      fault_any;

   // R1 start gating, R6 fault sources
   assign start_ok  = (mode_trickle ? vcc_ok_tc : vcc_ok_lr) && !vcc_uv && !vin_uv;
   assign fault_any = oc_trip || vin_uv || vcc_uv || enc_lost;

   ssfr_ctrl #(
      .RAMP_W      (RAMP_W),
      .SS_END_CODE (SS_END_CODE),
      .LR_OFF_CODE (LR_OFF_CODE),
      .RETRY_CODE  (RETRY_CODE),
      .FLT_LEN     (FLT_LEN)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_ok    (start_ok),
      .fault_any   (fault_any),
      .enc_present (enc_present),
      .sec_mode    (sec_mode),
      .ramp_q      (ramp),
      .cmd         (cmd),
      .active      (active),
      .flt_ind     (flt_ind),
      .lr_en       (lr_en)
   );

   ssfr_ramp #(
      .RAMP_W    (RAMP_W),
      .CHG_STEP  (CHG_STEP),
      .FAST_STEP (FAST_STEP),
      .SLOW_STEP (SLOW_STEP),
      .TOP_CODE  (LR_OFF_CODE),
      .MID_CODE  (SS_END_CODE),
      .LOW_CODE  (RETRY_CODE)
   ) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd    (cmd),
      .ramp_q (ramp)
   );

   ssfr_gate #(
      .VSL_LATCH (VSL_LATCH)
   ) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (active),
      .fault_any   (fault_any),
      .vsl_hit     (vsl_hit),
      .cycle_start (cycle_start),
      .gate_en     (gate_en)
   );

endmodule

// File: rtl/ssfr_seq_chk.sv
module ssfr_seq_chk #(
   parameter int RAMP_W      = 10,
   parameter int LR_OFF_CODE = 998,
   parameter int RETRY_CODE  = 51,
   parameter int FLT_LEN     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              oc_trip,
   input logic              vin_uv,
   input logic              vcc_uv,
   input logic              enc_lost,
   input logic              enc_present,
   input logic              vsl_hit,
   input logic              gate_en,
   input logic              flt_ind,
   input logic              lr_en,
   input logic [RAMP_W-1:0] ramp
);

   int unsigned run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= 0;
      else if (flt_ind) run_q <= run_q + 1;
      else              run_q <= 0;
   end

   // R6
   fault_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_trip || vin_uv || vcc_uv || enc_lost) |-> !gate_en);

   // R6
   fault_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt_ind) |-> (ramp == {RAMP_W{1'b1}}));

   // R7
   flt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flt_ind) |-> (run_q == FLT_LEN));

   // R7
   flt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flt_ind |-> (run_q < FLT_LEN));

   // R4
   enc_lr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_present |-> !lr_en);

   // R8
   lr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lr_en) |-> (ramp == RAMP_W'(RETRY_CODE)));

   // R10
   vsl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vsl_hit |-> !gate_en);

   // R2
   ramp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en |-> (ramp <= RAMP_W'(LR_OFF_CODE)));

endmodule

bind ssfr_seq ssfr_seq_chk #(
   .RAMP_W      (RAMP_W),
   .LR_OFF_CODE (LR_OFF_CODE),
   .RETRY_CODE  (RETRY_CODE),
   .FLT_LEN     (FLT_LEN)
) u_chk (.*);

// File: tb/ssfr_seq_tb.sv
module ssfr_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 150000;
   localparam int CHG   = 4;
   localparam int FAST  = 32;
   localparam int SLOW  = 2;
   localparam int SSEND = 716;
   localparam int LROFF = 998;
   localparam int RETRY = 51;
   localparam int FLEN  = 16;
   localparam int FULL  = 1023;

   // {mode_trickle, vcc_ok_lr, vcc_ok_tc, vcc_uv, vin_uv, expected gate_en}
   localparam logic [5:0] START_VEC [8] = '{
      6'b010001, 6'b001000, 6'b110000, 6'b111001,
      6'b010100, 6'b010010, 6'b111010, 6'b111100
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vcc_ok_lr = 0, vcc_ok_tc = 0, vcc_uv = 0, vin_uv = 0, oc_trip = 0;
   logic enc_lost = 0, enc_present = 0, mode_trickle = 0, sec_mode = 0;
   logic vsl_hit = 0, cycle_start = 0;
   logic gate_en, flt_ind, lr_en;
   logic [9:0] ramp;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 0;

   ssfr_seq u_dut (
      .clk(clk), .rst_n(rst_n), .vcc_ok_lr(vcc_ok_lr), .vcc_ok_tc(vcc_ok_tc),
      .vcc_uv(vcc_uv), .vin_uv(vin_uv), .oc_trip(oc_trip), .enc_lost(enc_lost),
      .enc_present(enc_present), .mode_trickle(mode_trickle), .sec_mode(sec_mode),
      .vsl_hit(vsl_hit), .cycle_start(cycle_start), .gate_en(gate_en),
      .flt_ind(flt_ind), .lr_en(lr_en), .ramp(ramp)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc >= WD_LIMIT && !done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cyc, WD_LIMIT);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 0;
      vcc_ok_lr = 0; vcc_ok_tc = 0; vcc_uv = 0; vin_uv = 0; oc_trip = 0;
      enc_lost = 0; enc_present = 0; mode_trickle = 0; sec_mode = 0;
      vsl_hit = 0; cycle_start = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic start_lr();
      vcc_ok_lr = 1;
      step(1);
   endtask

   task automatic wait_ramp(input int code, output int n);
      n = 0;
      while (int'(ramp) != code && n < 2000) begin
         step(1);
         n++;
      end
   endtask

   initial begin
      int n;
      int expv;
      int bad;

      // R1 reset state
      do_reset();
      #1;
      chk("R1 reset ramp", int'(ramp), 0);
      chk("R1 reset gate_en", int'(gate_en), 0);
      chk("R1 reset flt_ind", int'(flt_ind), 0);
      chk("R1 reset lr_en", int'(lr_en), 1);

      // R1 start gating table
      for (int i = 0; i < 8; i++) begin
         do_reset();
         {mode_trickle, vcc_ok_lr, vcc_ok_tc, vcc_uv, vin_uv} = START_VEC[i][5:1];
         step(1);
         chk("R1 start gating", int'(gate_en), int'(START_VEC[i][0]));
      end

      // R2 / R3 / R5: charge to timeout, linear regulator mode
      do_reset();
      start_lr();
      chk("R2 first soft-start ramp", int'(ramp), 0);
      step(1);
      chk("R2 one charge step", int'(ramp), CHG);
      wait_ramp(SSEND + CHG, n);
      chk("R5 lr_en kept when sec_mode=0", int'(lr_en), 1);
      wait_ramp(LROFF, n);
      chk("R2 clocks from end code to cap", n, (LROFF - SSEND - CHG + CHG - 1) / CHG);
      chk("R3 lr_en before timeout edge", int'(lr_en), 1);
      step(1);
      chk("R3 lr_en after timeout", int'(lr_en), 0);
      step(3);
      chk("R2 ramp saturates", int'(ramp), LROFF);

      // R10 volt-second cut
      chk("R10 gate before limit", int'(gate_en), 1);
      vsl_hit = 1; #1;
      chk("R10 gate cut same cycle", int'(gate_en), 0);
      step(1);
      vsl_hit = 0; #1;
      chk("R10 gate held off until cycle start", int'(gate_en), 0);
      chk("R10 no fault", int'(flt_ind), 0);
      cycle_start = 1;
      step(1);
      cycle_start = 0; #1;
      chk("R10 gate back after cycle start", int'(gate_en), 1);

      // R6 / R7 / R9 / R8 overcurrent fault and retry
      oc_trip = 1; #1;
      chk("R6 gate off at once", int'(gate_en), 0);
      step(1);
      oc_trip = 0; #1;
      chk("R6 flt_ind raised", int'(flt_ind), 1);
      chk("R6 ramp full scale", int'(ramp), FULL);
      chk("R4 lr stays locked in fault", int'(lr_en), 0);
      n = 0;
      while (flt_ind && n < 40) begin
         n++;
         enc_lost = (n == 5);
         step(1);
      end
      enc_lost = 0;
      chk("R7 pulse length", n, FLEN);
      chk("R9 ramp after pulse", int'(ramp), FULL);
      expv = FULL; bad = 0; n = 0;
      while (int'(ramp) != SSEND && n < 50) begin
         vin_uv = (n == 3);
         step(1);
         n++;
         expv = (expv - FAST > SSEND) ? expv - FAST : SSEND;
         if (int'(ramp) != expv) bad++;
      end
      vin_uv = 0;
      chk("R8 fast steps", bad, 0);
      chk("R9 fast clock count", n, (FULL - SSEND + FAST - 1) / FAST);
      step(1);
      chk("R8 dwell at end code", int'(ramp), SSEND);
      expv = SSEND; bad = 0; n = 0;
      while (int'(ramp) != RETRY && n < 1000) begin
         step(1);
         n++;
         expv = (expv - SLOW > RETRY) ? expv - SLOW : RETRY;
         if (int'(ramp) != expv) bad++;
      end
      chk("R8 slow steps", bad, 0);
      chk("R8 slow clock count", n, (SSEND - RETRY + SLOW - 1) / SLOW);
      step(1);
      chk("R8 lr_en back at retry", int'(lr_en), 1);
      chk("R8 gate still off in wait", int'(gate_en), 0);
      step(1);
      chk("R8 gate after retry", int'(gate_en), 1);
      step(1);
      chk("R8 charge from retry code", int'(ramp), RETRY + CHG);

      // R6 remaining sources
      for (int s = 0; s < 3; s++) begin
         do_reset();
         start_lr();
         step(5);
         case (s)
            0: vcc_uv = 1;
            1: vin_uv = 1;
            default: enc_lost = 1;
         endcase
         #1;
         chk("R6 source gate off", int'(gate_en), 0);
         step(1);
         vcc_uv = 0; vin_uv = 0; enc_lost = 0; #1;
         chk("R6 source flt_ind", int'(flt_ind), 1);
         chk("R6 source ramp full", int'(ramp), FULL);
      end

      // R4 encoded signal locks regulator off
      do_reset();
      sec_mode = 1;
      start_lr();
      step(10);
      enc_present = 1; #1;
      chk("R4 lr_en off same cycle", int'(lr_en), 0);
      step(1);
      enc_present = 0; #1;
      chk("R4 lr_en stays off", int'(lr_en), 0);
      wait_ramp(SSEND + 2 * CHG, n);
      chk("R4 lr_en off later", int'(lr_en), 0);
      chk("R4 gate unaffected", int'(gate_en), 1);

      // R5 early timeout in secondary mode without encoded signal
      do_reset();
      sec_mode = 1;
      start_lr();
      wait_ramp(SSEND, n);
      chk("R5 lr_en at end code", int'(lr_en), 1);
      step(1);
      chk("R5 lr_en after end code", int'(lr_en), 0);
      chk("R5 gate stays on", int'(gate_en), 1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule